// File: doc/BRIEF.md
# Expression Tree Instruction Expander

This block sits between the codeword fetch logic and a 16-bit processor core in a compressed-code execution path. The fetch side supplies the index of one decoded expression tree. The expander then replays the uncompressed instructions of that tree toward the core, one word per cycle, and needs no further memory fetch to do so. The tree contents live in a constant table inside the block. The table is computed at elaboration from its parameters. Each instruction word is assembled from separate fields: opcode, immediate, indirect mode and next register.

A tree may finish with a branch. A branch takes two words: the opcode word, followed by the uncompressed target. While the branch is current, the block raises a flag and exports two forms of the target. The uncompressed address serves the core. The compressed location, a word address plus a bit offset, lets the fetch logic refetch at the target. The block accepts a new tree index only after the last word of the current tree has been taken.

Top module: `exp_tree_expander`

## Requirements
- R1: After a synchronous active-low reset, `instr_valid` is 0, `cw_ready` is 1 and `branch_flag` is 0.
- R2: A codeword accepted at a clock edge (`cw_valid` and `cw_ready` both 1) makes `instr_valid` 1 after that edge, with the first word of the tree. Each word taken (`instr_valid` and `instr_ready` both 1) is replaced at the next edge by the following word, in order.
- R3: Tree t (0 to 7) holds n(t) = (t mod 4) + 1 instructions. Trees t >= 4 end in a branch, which adds one extra word.
- R4: Non-branch instruction j of tree t has opcode = 16 + 4t + j, placed in bits [15:8]. If j is even, bit 7 is 0 and bits [6:0] hold the immediate 8t + j. If j is odd, bit 7 is 1, bits [6:4] hold the indirect mode j, bit 3 is 0 and bits [2:0] hold the next register t.
- R5: In a branch tree, the last instruction is the opcode word {8'hBF, 1'b0, 7'(t)}. The next word is the uncompressed target, 16'h1000 + 32t.
- R6: While `branch_flag` is 1, `br_uaddr` = 16'h1000 + 32t, `br_cword` = 12'h200 + t and `br_coff` = (5t) mod 16, where t is the tree that raised the flag.
- R7: `branch_flag` rises when the branch opcode word is presented. It stays 1 through the target word and while idle. It clears when the first word of the next tree is presented, unless that word is itself a branch.
- R8: `cw_ready` is 1 only while no word is pending. It returns to 1 one cycle after the last word of a tree is taken.
- R9: While `instr_valid` is 1 and `instr_ready` is 0, `instr_word` and `instr_valid` hold their values.
- R10: `cw_valid` asserted while a tree is being expanded has no effect on the emitted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cw_valid | input | 1 | Tree index offered by fetch logic |
| cw_idx | input | 3 | Index of the tree to expand |
| cw_ready | output | 1 | Expander idle, can take an index |
| instr_valid | output | 1 | `instr_word` holds a word for the core |
| instr_ready | input | 1 | Core takes the current word |
| instr_word | output | 16 | Uncompressed instruction or branch target word |
| branch_flag | output | 1 | Branch currently expanded |
| br_uaddr | output | 16 | Uncompressed branch target |
| br_cword | output | 12 | Compressed target word address |
| br_coff | output | 4 | Compressed target bit offset within the word |

## Verification
A corrupted slot counter or tree register shows up in the very next word presented. It appears as a wrong opcode or field, a word that is skipped or repeated, or a sequence that is too short or too long. A wrong state bit either drops the target word after a branch or leaves `cw_ready` low or high at the wrong time. The error is visible within one cycle of the handshake that should have moved the state on. A lost hold bit makes `branch_flag` fall in the idle cycle after a branch tree, and this is caught as soon as that tree ends.

// File: rtl/exp_pkg.sv
// Package: shared types and the constant tree-table generators for the
// expression tree instruction expander. Assumes 16-bit instruction words
// made of an 8-bit opcode plus an 8-bit operand field.
package exp_pkg;

    localparam int WORD_W   = 16;
    localparam int OP_W     = 8;
    localparam int IMM_W    = 7;
    localparam int MODE_W   = 3;
    localparam int REG_W    = 3;
    localparam int CWORD_W  = 12;
    localparam int COFF_W   = 4;
    localparam int CNT_W    = 8;
    localparam logic [OP_W-1:0] BR_OPCODE = 8'hBF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_TARGET = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [OP_W-1:0]   opcode;
        logic              indirect;
        logic [IMM_W-1:0]  immed;
        logic [MODE_W-1:0] ind_mode;
        logic [REG_W-1:0]  next_reg;
        logic              is_branch;
    } instr_fields_t;

    typedef struct packed {
        logic [CNT_W-1:0]   count;
        logic               has_branch;
        logic [WORD_W-1:0]  uaddr;
        logic [CWORD_W-1:0] cword;
        logic [COFF_W-1:0]  coff;
    } tree_hdr_t;

    // Number of instructions held by tree t.
    function automatic int tree_len(int t, int max_instr);
        return (t % max_instr) + 1;
    endfunction

    // Per-tree header: length, branch presence and both target forms.
    function automatic tree_hdr_t make_hdr(int t, int max_instr, int branch_from);
        tree_hdr_t h;
        h.count      = CNT_W'(tree_len(t, max_instr));
        h.has_branch = (t >= branch_from);
        h.uaddr      = WORD_W'(4096 + t * 32);
        h.cword      = CWORD_W'(512 + t);
        h.coff       = COFF_W'(t * 5);
        return h;
    endfunction

    // Field set of instruction j in tree t; unused slots are all zero.
    function automatic instr_fields_t make_fields(int t, int j, int max_instr,
                                                  int branch_from);
        instr_fields_t f;
        int n;
        f = '0;
        n = tree_len(t, max_instr);
        if (j < n) begin
            if ((t >= branch_from) && (j == n - 1)) begin
                f.opcode    = BR_OPCODE;
                f.immed     = IMM_W'(t);
                f.is_branch = 1'b1;
            end else begin
                f.opcode = OP_W'(16 + max_instr * t + j);
                if ((j % 2) == 1) begin
                    f.indirect = 1'b1;
                    f.ind_mode = MODE_W'(j);
                    f.next_reg = REG_W'(t);
                end else begin
                    f.immed = IMM_W'(t * 8 + j);
                end
            end
        end
        return f;
    endfunction

endpackage

// File: rtl/exp_tree_rom.sv
// Module: constant tree table. Returns the header of the selected tree and
// the instruction fields of one slot of it. Purely combinational.
// Assumes tree_idx < NUM_TREES and slot < MAX_INSTR.
module exp_tree_rom #(
    parameter int NUM_TREES   = 8,
    parameter int MAX_INSTR   = 4,
    parameter int BRANCH_FROM = 4,
    localparam int IDX_W  = $clog2(NUM_TREES),
    localparam int SLOT_W = (MAX_INSTR > 1) ? $clog2(MAX_INSTR) : 1
) (
    input  logic [IDX_W-1:0]         tree_idx,
    input  logic [SLOT_W-1:0]        slot,
    output exp_pkg::tree_hdr_t       hdr,
    output exp_pkg::instr_fields_t   fields
);
    import exp_pkg::*;

    tree_hdr_t     hdr_tab [NUM_TREES];
    instr_fields_t fld_tab [NUM_TREES][MAX_INSTR];

    // Table contents computed at elaboration from the generator functions.
    for (genvar t = 0; t < NUM_TREES; t++) begin : g_tree
        assign hdr_tab[t] = make_hdr(t, MAX_INSTR, BRANCH_FROM);
        for (genvar j = 0; j < MAX_INSTR; j++) begin : g_slot
            assign fld_tab[t][j] = make_fields(t, j, MAX_INSTR, BRANCH_FROM);
        end
    end

    // Table lookup with a guard for indices outside the table.
    always_comb begin
        hdr    = '0;
        fields = '0;
        if (int'(tree_idx) < NUM_TREES) begin
            hdr = hdr_tab[tree_idx];
            if (int'(slot) < MAX_INSTR) begin
                fields = fld_tab[tree_idx][slot];
            end
        end
    end

endmodule

// File: rtl/exp_sequencer.sv
// Module: tree sequencer. Accepts a tree index when idle, steps through the
// instruction slots on each output handshake, inserts the target word after
// a branch, and keeps a hold bit for the branch flag once the tree is done.
// Assumes the header inputs describe the tree held in tree_q.
module exp_sequencer #(
    parameter int NUM_TREES = 8,
    parameter int MAX_INSTR = 4,
    localparam int IDX_W  = $clog2(NUM_TREES),
    localparam int SLOT_W = (MAX_INSTR > 1) ? $clog2(MAX_INSTR) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cw_valid,
    input  logic [IDX_W-1:0]              cw_idx,
    input  logic                          instr_ready,
    input  logic [exp_pkg::CNT_W-1:0]     tree_count,
    input  logic                          tree_has_branch,
    output exp_pkg::seq_state_e           state_q,
    output logic [IDX_W-1:0]              tree_q,
    output logic [SLOT_W-1:0]             slot_q,
    output logic                          hold_q,
    output logic                          cw_ready,
    output logic                          instr_valid
);
    import exp_pkg::*;

    logic fire;
    logic take;
    logic last_slot;

    // Handshake decode for both sides.
    always_comb begin
        cw_ready    = (state_q == ST_IDLE);
        instr_valid = (state_q != ST_IDLE);
        take        = cw_valid && cw_ready;
        fire        = instr_valid && instr_ready;
        last_slot   = (CNT_W'(slot_q) == (tree_count - CNT_W'(1)));
    end

    // State, slot pointer, tree register and branch hold bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tree_q  <= '0;
            slot_q  <= '0;
            hold_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        tree_q  <= cw_idx;
                        slot_q  <= '0;
                        hold_q  <= 1'b0;
                        state_q <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (fire) begin
                        if (last_slot) begin
                            state_q <= tree_has_branch ? ST_TARGET : ST_IDLE;
                        end else begin
                            slot_q <= slot_q + SLOT_W'(1);
                        end
                    end
                end
                ST_TARGET: begin
                    if (fire) begin
                        state_q <= ST_IDLE;
                        hold_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/exp_asm_buffer.sv
// Module: instruction assembly buffer. Packs the field set of the current
// slot into a 16-bit word, substitutes the uncompressed target in the
// target phase, and forms the branch flag. Combinational.
module exp_asm_buffer (
    input  exp_pkg::seq_state_e            state_q,
    input  logic                           hold_q,
    input  exp_pkg::instr_fields_t         fields,
    input  logic [exp_pkg::WORD_W-1:0]     uaddr,
    output logic [exp_pkg::WORD_W-1:0]     instr_word,
    output logic                           branch_flag
);
    import exp_pkg::*;

    logic [WORD_W-1:0] packed_word;

    // Operand layout selected by the addressing mode bit.
    always_comb begin
        if (fields.indirect) begin
            packed_word = {fields.opcode, 1'b1, fields.ind_mode, 1'b0, fields.next_reg};
        end else begin
            packed_word = {fields.opcode, 1'b0, fields.immed};
        end
    end

    // Output word mux and branch flag.
    always_comb begin
        case (state_q)
            ST_EMIT:   instr_word = packed_word;
            ST_TARGET: instr_word = uaddr;
            default:   instr_word = '0;
        endcase
        branch_flag = hold_q
                   || (state_q == ST_TARGET)
                   || ((state_q == ST_EMIT) && fields.is_branch);
    end

endmodule

// File: rtl/exp_tree_expander.sv
// Module: top of the expression tree instruction expander. Takes one tree
// index from the fetch side and emits the tree's instruction words toward
// the core with a valid/ready handshake. Branch targets in both forms are
// exported while the branch flag is high.
// Assumes cw_idx < NUM_TREES.
module exp_tree_expander #(
    parameter int NUM_TREES   = 8,
    parameter int MAX_INSTR   = 4,
    parameter int BRANCH_FROM = 4,
    localparam int IDX_W = $clog2(NUM_TREES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cw_valid,
    input  logic [IDX_W-1:0]               cw_idx,
    output logic                           cw_ready,
    output logic                           instr_valid,
    input  logic                           instr_ready,
    output logic [exp_pkg::WORD_W-1:0]     instr_word,
    output logic                           branch_flag,
    output logic [exp_pkg::WORD_W-1:0]     br_uaddr,
    output logic [exp_pkg::CWORD_W-1:0]    br_cword,
    output logic [exp_pkg::COFF_W-1:0]     br_coff
);
    import exp_pkg::*;

    localparam int SLOT_W = (MAX_INSTR > 1) ? $clog2(MAX_INSTR) : 1;

    seq_state_e    state_q;
    logic [IDX_W-1:0]  tree_q;
    logic [SLOT_W-1:0] slot_q;
    logic          hold_q;
    tree_hdr_t     hdr;
    instr_fields_t fields;

    exp_tree_rom #(
        .NUM_TREES  (NUM_TREES),
        .MAX_INSTR  (MAX_INSTR),
        .BRANCH_FROM(BRANCH_FROM)
    ) u_rom (
        .tree_idx(tree_q),
        .slot    (slot_q),
        .hdr     (hdr),
        .fields  (fields)
    );

    exp_sequencer #(
        .NUM_TREES(NUM_TREES),
        .MAX_INSTR(MAX_INSTR)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cw_valid       (cw_valid),
        .cw_idx         (cw_idx),
        .instr_ready    (instr_ready),
        .tree_count     (hdr.count),
        .tree_has_branch(hdr.has_branch),
        .state_q        (state_q),
        .tree_q         (tree_q),
        .slot_q         (slot_q),
        .hold_q         (hold_q),
        .cw_ready       (cw_ready),
        .instr_valid    (instr_valid)
    );

    exp_asm_buffer u_asm (
        .state_q    (state_q),
        .hold_q     (hold_q),
        .fields     (fields),
        .uaddr      (hdr.uaddr),
        .instr_word (instr_word),
        .branch_flag(branch_flag)
    );

    // Both target forms come from the header of the tree last accepted.
    always_comb begin
        br_uaddr = hdr.uaddr;
        br_cword = hdr.cword;
        br_coff  = hdr.coff;
    end

endmodule

// File: rtl/exp_checker.sv
// Module: protocol checker for the expander, attached by bind.
module exp_checker #(
    parameter int IDX_W = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cw_valid,
    input logic [IDX_W-1:0]               cw_idx,
    input logic                           cw_ready,
    input logic                           instr_valid,
    input logic                           instr_ready,
    input logic [exp_pkg::WORD_W-1:0]     instr_word,
    input logic                           branch_flag,
    input logic [exp_pkg::WORD_W-1:0]     br_uaddr,
    input logic [exp_pkg::CWORD_W-1:0]    br_cword,
    input logic [exp_pkg::COFF_W-1:0]     br_coff
);
    logic unused_ok;
    assign unused_ok = ^{cw_idx, br_cword, br_coff};

    // R2: an accepted codeword yields a word on the next cycle.
    assert_accept_emits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cw_ready) |=> instr_valid);

    // R8: idle and busy are mutually exclusive at the ports.
    assert_ready_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cw_ready && instr_valid));

    // R9: a stalled word holds.
    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !instr_ready) |=> (instr_valid && $stable(instr_word)));

    // R5: a taken branch opcode word is always followed by its target word.
    assert_branch_has_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && branch_flag && instr_word[15:8] == 8'hBF)
        |=> (instr_valid && instr_word == br_uaddr));

    // R6: targets do not move while the flag stays high without a new tree.
    assert_targets_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(branch_flag) && branch_flag && !$past(cw_valid && cw_ready))
        |-> $stable(br_uaddr));

    // R7: the flag cannot drop while the target word waits.
    assert_flag_through_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_flag && instr_valid && !instr_ready) |=> branch_flag);

endmodule

bind exp_tree_expander exp_checker #(.IDX_W(IDX_W)) u_exp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cw_valid   (cw_valid),
    .cw_idx     (cw_idx),
    .cw_ready   (cw_ready),
    .instr_valid(instr_valid),
    .instr_ready(instr_ready),
    .instr_word (instr_word),
    .branch_flag(branch_flag),
    .br_uaddr   (br_uaddr),
    .br_cword   (br_cword),
    .br_coff    (br_coff)
);

// File: tb/test_exp_tree_expander.sv
// Bench: directed and seeded-random tree expansions with random core stalls,
// compared against a model of the tree table written from the requirements.
module test_exp_tree_expander;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cw_valid = 1'b0;
    logic [2:0]  cw_idx = '0;
    logic        cw_ready;
    logic        instr_valid;
    logic        instr_ready = 1'b0;
    logic [15:0] instr_word;
    logic        branch_flag;
    logic [15:0] br_uaddr;
    logic [11:0] br_cword;
    logic [3:0]  br_coff;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    exp_tree_expander i_exp_tree_expander (
        .clk        (clk),
        .rst_n      (rst_n),
        .cw_valid   (cw_valid),
        .cw_idx     (cw_idx),
        .cw_ready   (cw_ready),
        .instr_valid(instr_valid),
        .instr_ready(instr_ready),
        .instr_word (instr_word),
        .branch_flag(branch_flag),
        .br_uaddr   (br_uaddr),
        .br_cword   (br_cword),
        .br_coff    (br_coff)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic int e_len(int t);
        return (t % 4) + 1;
    endfunction

    function automatic bit e_br(int t);
        return t >= 4;
    endfunction

    function automatic int e_nwords(int t);
        return e_len(t) + (e_br(t) ? 1 : 0);
    endfunction

    function automatic logic [15:0] e_word(int t, int k);
        logic [7:0] op;
        int n;
        n = e_len(t);
        if (e_br(t) && k == n) return 16'(4096 + 32 * t);
        if (e_br(t) && k == n - 1) return {8'hBF, 1'b0, 7'(t)};
        op = 8'(16 + 4 * t + k);
        if ((k % 2) == 1) return {op, 1'b1, 3'(k), 1'b0, 3'(t)};
        return {op, 1'b0, 7'(8 * t + k)};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expand one tree; stall_pct sets the core stall rate, noise drives
    // cw_valid during the expansion (R10).
    task automatic run_tree(int t, int stall_pct, bit noise);
        int k;
        int nw;
        int n;
        logic [15:0] ew;
        bit eflag;
        nw = e_nwords(t);
        n  = e_len(t);
        while (!cw_ready) @(negedge clk);
        cw_idx   = 3'(t);
        cw_valid = 1'b1;
        @(negedge clk);
        cw_valid = 1'b0;
        chk(instr_valid == 1'b1, "R2 valid after accept", 32'(instr_valid), 32'd1);
        chk(cw_ready == 1'b0, "R8 busy after accept", 32'(cw_ready), 32'd0);
        k = 0;
        while (k < nw) begin
            if (noise) begin
                cw_valid = (k < nw - 1);
                cw_idx   = 3'(t + 3);
            end
            ew    = e_word(t, k);
            eflag = e_br(t) && (k >= n - 1);
            if (e_br(t) && k >= n - 1)
                chk(instr_word == ew, noise ? "R5/R10 branch word" : "R5 branch word",
                    32'(instr_word), 32'(ew));
            else
                chk(instr_word == ew, noise ? "R4/R10 word" : "R4 word",
                    32'(instr_word), 32'(ew));
            chk(instr_valid == 1'b1, "R3 word count", 32'(instr_valid), 32'd1);
            chk(branch_flag == eflag, "R7 branch flag", 32'(branch_flag), 32'(eflag));
            if (eflag) begin
                chk(br_uaddr == 16'(4096 + 32 * t), "R6 uaddr", 32'(br_uaddr), 32'(4096 + 32 * t));
                chk(br_cword == 12'(512 + t), "R6 cword", 32'(br_cword), 32'(512 + t));
                chk(br_coff == 4'(5 * t), "R6 coff", 32'(br_coff), 32'(4'(5 * t)));
            end
            if (($urandom % 100) < stall_pct) begin
                instr_ready = 1'b0;
                @(negedge clk);
                chk(instr_word == ew && instr_valid, "R9 stall hold", 32'(instr_word), 32'(ew));
            end else begin
                instr_ready = 1'b1;
                @(negedge clk);
                instr_ready = 1'b0;
                k = k + 1;
            end
        end
        cw_valid = 1'b0;
        chk(instr_valid == 1'b0, "R3 sequence ends", 32'(instr_valid), 32'd0);
        chk(cw_ready == 1'b1, "R8 ready after last word", 32'(cw_ready), 32'd1);
        chk(branch_flag == e_br(t), "R7 flag held when idle", 32'(branch_flag), 32'(e_br(t)));
        if (e_br(t))
            chk(br_cword == 12'(512 + t), "R6 cword when idle", 32'(br_cword), 32'(512 + t));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(instr_valid == 1'b0, "R1 valid low", 32'(instr_valid), 32'd0);
        chk(cw_ready == 1'b1, "R1 ready high", 32'(cw_ready), 32'd1);
        chk(branch_flag == 1'b0, "R1 flag low", 32'(branch_flag), 32'd0);

        // Directed: one-word, three-word, branch-only and multi-word branch trees.
        run_tree(0, 0, 1'b0);
        run_tree(2, 0, 1'b0);
        run_tree(4, 0, 1'b0);
        run_tree(6, 0, 1'b0);
        run_tree(1, 0, 1'b0);   // R7: flag clears on a non-branch word
        run_tree(7, 50, 1'b0);
        run_tree(3, 60, 1'b0);
        run_tree(6, 30, 1'b1);  // R10: codeword offered while busy
        run_tree(2, 30, 1'b1);

        // Seeded random trees with random stalls.
        for (int i = 0; i < 60; i++) begin
            run_tree(int'($urandom % 8), int'($urandom % 70), 1'($urandom % 2));
        end

        // R1 again: reset in the middle of a tree.
        while (!cw_ready) @(negedge clk);
        cw_idx = 3'd7; cw_valid = 1'b1;
        @(negedge clk);
        cw_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(instr_valid == 1'b0 && cw_ready == 1'b1 && branch_flag == 1'b0,
            "R1 mid-tree reset", {29'd0, instr_valid, cw_ready, branch_flag}, 32'd2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule